// File: doc/BRIEF.md
# Credit-Based Configuration Replacement Manager

This block keeps track of which configurations currently occupy a row-based reconfigurable array. It decides which ones to throw out when a new one needs room. The table has a fixed number of slots. Each resident configuration holds an identifier, its size in rows and a credit value. A request names a configuration identifier and its row count. The block answers with a hit when that identifier is already resident. On a miss it makes room and records the new configuration as resident.

Room is made one victim at a time. Each victim is the resident entry with the smallest credit, and finding it takes a serial pass over the table. Every eviction is reported on an eviction strobe together with the evicted identifier. The credit of every surviving entry is then lowered by the victim's credit. A configuration that is used again has its credit restored to its size. As a result, large and recently used configurations survive longer than small, idle ones. Free rows are counted as a total only: the free space may be scattered, and a separate compaction step is assumed to gather it. Placing, compacting and loading the configuration data are done elsewhere.

Top module: `crm_manager`

## Requirements
- R1: A legal request whose identifier is resident gives a response with the hit flag set. It causes no eviction and leaves the free-row count unchanged. It resets that entry's credit to the size stored when the entry was loaded; the size in the request is not used.
- R2: A legal request that misses, when free rows are at least the requested size and a slot is empty, loads into the lowest-numbered empty slot. That entry's credit becomes the requested size, the free-row count drops by that size, and the response has both hit and reject clear.
- R3: Each victim is the resident entry with the smallest credit. When credits are equal, the lowest-numbered slot is chosen. The victim's identifier appears on the eviction output.
- R4: After each eviction, every remaining resident entry's credit is reduced by the victim's credit.
- R5: Each eviction raises the free-row count by the victim's size.
- R6: On a miss, evictions repeat only while free rows are fewer than the requested size or no slot is empty. They stop as soon as both conditions are met.
- R7: A request of size 0, or of more than the array's row count, is answered with the reject flag set. It evicts nothing and changes neither the table nor the free-row count. This legality check comes before the lookup.
- R8: A request is accepted when request-valid and ready are both high at a clock edge. With k evictions, the response pulse appears for one cycle, 2 + k*(NUM_SLOTS+1) cycles after acceptance. Eviction j (counting from 0) pulses for one cycle, 1 + (j+1)*(NUM_SLOTS+1) cycles after acceptance. Ready stays low from acceptance until the response cycle.
- R9: After reset, the table is empty and ready is high. The free-row count equals the array's row count, and no response or eviction pulse is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_id | input | ID_W | Requested configuration identifier |
| req_size | input | ROW_W | Requested configuration size in rows |
| ready | output | 1 | Block idle, request can be accepted |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | Response: identifier was resident |
| resp_reject | output | 1 | Response: illegal size, nothing done |
| evict_valid | output | 1 | One-cycle eviction pulse |
| evict_id | output | ID_W | Identifier of the evicted configuration |
| free_rows | output | ROW_W | Total unoccupied rows |

## Verification
The bench targets credit ties and checks that the lower slot is evicted; a design that scanned with a non-strict compare would evict the higher slot instead. It runs a hit that carries a different size and checks that the later eviction order follows the stored size; a design that used the requested size would evict a different entry. It issues a request that needs several evictions, one that fills all slots while rows remain free, and one as large as the whole array. Together these expose a wrong stop condition, missed credit subtraction, or a wrong number or timing of eviction pulses. Size-0 and oversize requests check that a reject leaves free rows unchanged and raises no eviction strobe.

// File: rtl/crm_pkg.sv
package crm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_SCAN
    } crm_state_e;

    typedef enum logic [1:0] {
        TOP_NONE,
        TOP_TOUCH,
        TOP_LOAD,
        TOP_EVICT
    } tab_op_e;

    typedef struct packed {
        logic valid;
        logic hit;
        logic reject;
    } crm_resp_t;

    // A size is legal when it is non-zero and fits in the array.
    function automatic logic size_ok(input int unsigned sz, input int unsigned limit);
        return (sz != 0) && (sz <= limit);
    endfunction

endpackage

// File: rtl/crm_table.sv
module crm_table
    import crm_pkg::*;
#(
    parameter int N   = 4,
    parameter int IDW = 4,
    parameter int RW  = 4,
    localparam int IXW = $clog2(N)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [IDW-1:0]        lookup_id,
    input  tab_op_e               op,
    input  logic [IXW-1:0]        op_idx,
    input  logic [IDW-1:0]        load_id,
    input  logic [RW-1:0]         load_size,
    input  logic [RW-1:0]         victim_credit,
    output logic [N-1:0]          valid_o,
    output logic [N-1:0][IDW-1:0] id_o,
    output logic [N-1:0][RW-1:0]  size_o,
    output logic [N-1:0][RW-1:0]  credit_o,
    output logic                  hit,
    output logic [IXW-1:0]        hit_idx,
    output logic                  has_empty,
    output logic [IXW-1:0]        empty_idx
);

    logic           valid_q  [N];
    logic [IDW-1:0] id_q     [N];
    logic [RW-1:0]  size_q   [N];
    logic [RW-1:0]  credit_q [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        logic sel;
        assign sel = (op_idx == IXW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[g]  <= 1'b0;
                id_q[g]     <= '0;
                size_q[g]   <= '0;
                credit_q[g] <= '0;
            end else begin
                case (op)
                    TOP_TOUCH: if (sel) credit_q[g] <= size_q[g];
                    TOP_LOAD: if (sel) begin
                        valid_q[g]  <= 1'b1;
                        id_q[g]     <= load_id;
                        size_q[g]   <= load_size;
                        credit_q[g] <= load_size;
                    end
                    TOP_EVICT: begin
                        if (sel) valid_q[g] <= 1'b0;
                        else if (valid_q[g]) credit_q[g] <= credit_q[g] - victim_credit;
                    end
                    default: ;
                endcase
            end
        end

        assign valid_o[g]  = valid_q[g];
        assign id_o[g]     = id_q[g];
        assign size_o[g]   = size_q[g];
        assign credit_o[g] = credit_q[g];
    end

    // Lowest matching slot and lowest empty slot.
    always_comb begin
        hit       = 1'b0;
        hit_idx   = '0;
        has_empty = 1'b0;
        empty_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (valid_q[i] && id_q[i] == lookup_id) begin
                hit     = 1'b1;
                hit_idx = IXW'(i);
            end
            if (!valid_q[i]) begin
                has_empty = 1'b1;
                empty_idx = IXW'(i);
            end
        end
    end

    assert_touch_resident_R1: assert property (@(posedge clk) disable iff (rst)
        op == TOP_TOUCH |-> valid_o[op_idx]);

    assert_load_empty_R2: assert property (@(posedge clk) disable iff (rst)
        op == TOP_LOAD |-> !valid_o[op_idx]);

endmodule

// File: rtl/crm_victim_scan.sv
module crm_victim_scan #(
    parameter int N  = 4,
    parameter int RW = 4,
    localparam int IXW = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [N-1:0]         valid_i,
    input  logic [N-1:0][RW-1:0] credit_i,
    output logic                 done_o,
    output logic [IXW-1:0]       victim_o
);

    logic           busy_q;
    logic           found_q;
    logic [IXW-1:0] idx_q;
    logic [IXW-1:0] best_idx_q;
    logic [RW-1:0]  best_cred_q;
    logic           take;

    // Strict compare keeps the earlier (lower) slot on equal credit.
    assign take     = valid_i[idx_q] && (!found_q || credit_i[idx_q] < best_cred_q);
    assign done_o   = busy_q && (idx_q == IXW'(N - 1));
    assign victim_o = take ? idx_q : best_idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q      <= 1'b0;
            found_q     <= 1'b0;
            idx_q       <= '0;
            best_idx_q  <= '0;
            best_cred_q <= '0;
        end else if (start) begin
            busy_q  <= 1'b1;
            found_q <= 1'b0;
            idx_q   <= '0;
        end else if (busy_q) begin
            if (take) begin
                found_q     <= 1'b1;
                best_idx_q  <= idx_q;
                best_cred_q <= credit_i[idx_q];
            end
            if (done_o) busy_q <= 1'b0;
            else        idx_q  <= idx_q + 1'b1;
        end
    end

    assert_victim_resident_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> valid_i[victim_o]);

endmodule

// File: rtl/crm_manager.sv
module crm_manager
    import crm_pkg::*;
#(
    parameter int NUM_SLOTS  = 4,
    parameter int ID_W       = 4,
    parameter int ARRAY_ROWS = 12,
    localparam int ROW_W = $clog2(ARRAY_ROWS + 1),
    localparam int IDX_W = $clog2(NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [ID_W-1:0]  req_id,
    input  logic [ROW_W-1:0] req_size,
    output logic             ready,
    output logic             resp_valid,
    output logic             resp_hit,
    output logic             resp_reject,
    output logic             evict_valid,
    output logic [ID_W-1:0]  evict_id,
    output logic [ROW_W-1:0] free_rows
);

    crm_state_e       state_q;
    logic [ID_W-1:0]  id_q;
    logic [ROW_W-1:0] size_q;
    logic [ROW_W-1:0] free_q;
    crm_resp_t        resp_q;
    logic             ev_valid_q;
    logic [ID_W-1:0]  ev_id_q;

    logic [NUM_SLOTS-1:0]             t_valid;
    logic [NUM_SLOTS-1:0][ID_W-1:0]   t_id;
    logic [NUM_SLOTS-1:0][ROW_W-1:0]  t_size;
    logic [NUM_SLOTS-1:0][ROW_W-1:0]  t_credit;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic             has_empty;
    logic [IDX_W-1:0] empty_idx;
    logic             scan_done;
    logic [IDX_W-1:0] victim_idx;

    tab_op_e          op;
    logic [IDX_W-1:0] op_idx;
    logic             scan_start;
    logic             bad;
    logic             need_room;

    assign bad       = !size_ok(32'(size_q), ARRAY_ROWS);
    assign need_room = (free_q < size_q) || !has_empty;

    always_comb begin
        op         = TOP_NONE;
        op_idx     = '0;
        scan_start = 1'b0;
        case (state_q)
            ST_CHECK: if (!bad) begin
                if (hit) begin
                    op     = TOP_TOUCH;
                    op_idx = hit_idx;
                end else if (!need_room) begin
                    op     = TOP_LOAD;
                    op_idx = empty_idx;
                end else begin
                    scan_start = 1'b1;
                end
            end
            ST_SCAN: if (scan_done) begin
                op     = TOP_EVICT;
                op_idx = victim_idx;
            end
            default: ;
        endcase
    end

    crm_table #(.N(NUM_SLOTS), .IDW(ID_W), .RW(ROW_W)) u_table (
        .clk          (clk),
        .rst          (rst),
        .lookup_id    (id_q),
        .op           (op),
        .op_idx       (op_idx),
        .load_id      (id_q),
        .load_size    (size_q),
        .victim_credit(t_credit[victim_idx]),
        .valid_o      (t_valid),
        .id_o         (t_id),
        .size_o       (t_size),
        .credit_o     (t_credit),
        .hit          (hit),
        .hit_idx      (hit_idx),
        .has_empty    (has_empty),
        .empty_idx    (empty_idx)
    );

    crm_victim_scan #(.N(NUM_SLOTS), .RW(ROW_W)) u_scan (
        .clk     (clk),
        .rst     (rst),
        .start   (scan_start),
        .valid_i (t_valid),
        .credit_i(t_credit),
        .done_o  (scan_done),
        .victim_o(victim_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            id_q       <= '0;
            size_q     <= '0;
            free_q     <= ROW_W'(ARRAY_ROWS);
            resp_q     <= '0;
            ev_valid_q <= 1'b0;
            ev_id_q    <= '0;
        end else begin
            resp_q     <= '0;
            ev_valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    id_q    <= req_id;
                    size_q  <= req_size;
                    state_q <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (bad) begin
                        resp_q  <= '{valid: 1'b1, hit: 1'b0, reject: 1'b1};
                        state_q <= ST_IDLE;
                    end else if (hit) begin
                        resp_q  <= '{valid: 1'b1, hit: 1'b1, reject: 1'b0};
                        state_q <= ST_IDLE;
                    end else if (!need_room) begin
                        free_q  <= free_q - size_q;
                        resp_q  <= '{valid: 1'b1, hit: 1'b0, reject: 1'b0};
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_SCAN;
                    end
                end
                ST_SCAN: if (scan_done) begin
                    free_q     <= free_q + t_size[victim_idx];
                    ev_valid_q <= 1'b1;
                    ev_id_q    <= t_id[victim_idx];
                    state_q    <= ST_CHECK;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ready       = (state_q == ST_IDLE);
    assign resp_valid  = resp_q.valid;
    assign resp_hit    = resp_q.hit;
    assign resp_reject = resp_q.reject;
    assign evict_valid = ev_valid_q;
    assign evict_id    = ev_id_q;
    assign free_rows   = free_q;

    assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(evict_valid && resp_valid));

    assert_busy_on_evict_R8: assert property (@(posedge clk) disable iff (rst)
        evict_valid |-> !ready);

    assert_reject_static_R7: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_reject) |-> $stable(free_rows));

    assert_hit_static_R1: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_hit) |-> $stable(free_rows));

    assert_free_grows_R5: assert property (@(posedge clk) disable iff (rst)
        evict_valid |-> (free_rows > $past(free_rows)));

    assert_free_bound_R2: assert property (@(posedge clk) disable iff (rst)
        free_rows <= ROW_W'(ARRAY_ROWS));

endmodule

// File: tb/crm_manager_bench.sv
module crm_manager_bench;

    localparam int N    = 4;
    localparam int IDW  = 4;
    localparam int ROWS = 12;
    localparam int RW   = $clog2(ROWS + 1);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           req_valid = 1'b0;
    logic [IDW-1:0] req_id = '0;
    logic [RW-1:0]  req_size = '0;
    logic           ready, resp_valid, resp_hit, resp_reject, evict_valid;
    logic [IDW-1:0] evict_id;
    logic [RW-1:0]  free_rows;

    always #5 clk = ~clk;

    crm_manager #(.NUM_SLOTS(N), .ID_W(IDW), .ARRAY_ROWS(ROWS)) u_crm_manager (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_id(req_id),
        .req_size(req_size), .ready(ready), .resp_valid(resp_valid),
        .resp_hit(resp_hit), .resp_reject(resp_reject),
        .evict_valid(evict_valid), .evict_id(evict_id), .free_rows(free_rows)
    );

    int nchecks = 0;
    int nfail   = 0;

    // Behavioural reference state.
    bit mv  [N];
    int mid [N];
    int msz [N];
    int mcr [N];
    int mfree;
    int exp_vq[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            mv[i] = 0; mid[i] = 0; msz[i] = 0; mcr[i] = 0;
        end
        mfree = ROWS;
    endtask

    task automatic model(input int id, input int size, output bit eh, output bit er);
        int empty;
        int best;
        exp_vq.delete();
        eh = 0;
        er = 0;
        if (size == 0 || size > ROWS) begin
            er = 1;
            return;
        end
        for (int i = 0; i < N; i++) begin
            if (mv[i] && mid[i] == id) begin
                mcr[i] = msz[i];
                eh = 1;
                return;
            end
        end
        for (int guard = 0; guard <= N; guard++) begin
            empty = -1;
            for (int i = N - 1; i >= 0; i--) if (!mv[i]) empty = i;
            if (mfree >= size && empty >= 0) break;
            best = -1;
            for (int i = 0; i < N; i++)
                if (mv[i] && (best < 0 || mcr[i] < mcr[best])) best = i;
            exp_vq.push_back(mid[best]);
            mfree += msz[best];
            mv[best] = 0;
            for (int i = 0; i < N; i++) if (mv[i]) mcr[i] -= mcr[best];
        end
        empty = -1;
        for (int i = N - 1; i >= 0; i--) if (!mv[i]) empty = i;
        mv[empty] = 1; mid[empty] = id; msz[empty] = size; mcr[empty] = size;
        mfree -= size;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        check(ready == 1'b1, "R9", "ready after reset", int'(ready), 1);
        check(free_rows == RW'(ROWS), "R9", "free rows after reset", int'(free_rows), ROWS);
        check(resp_valid == 1'b0, "R9", "resp pulse after reset", int'(resp_valid), 0);
        check(evict_valid == 1'b0, "R9", "evict pulse after reset", int'(evict_valid), 0);
    endtask

    // Compare every cycle of one request against the model's expectations.
    task automatic run_req(input int id, input int size);
        bit eh, er, done, ev_exp;
        int k, cyc, vi, resp_at;
        model(id, size, eh, er);
        k = exp_vq.size();
        resp_at = 2 + k * (N + 1);
        @(negedge clk);
        req_valid = 1'b1;
        req_id    = IDW'(id);
        req_size  = RW'(size);
        @(negedge clk);
        req_valid = 1'b0;
        cyc  = 1;
        vi   = 0;
        done = 0;
        while (!done) begin
            ev_exp = (cyc > 1) && (cyc < resp_at) && (((cyc - 1) % (N + 1)) == 0);
            check(evict_valid == ev_exp, "R6", "eviction pulse", int'(evict_valid), int'(ev_exp));
            if (ev_exp && evict_valid) begin
                check(int'(evict_id) == exp_vq[vi], "R3/R4", "victim id", int'(evict_id), exp_vq[vi]);
                vi++;
            end
            check(resp_valid == (cyc == resp_at), "R8", "response timing",
                  int'(resp_valid), int'(cyc == resp_at));
            check(ready == (cyc >= resp_at), "R8", "ready", int'(ready), int'(cyc >= resp_at));
            if (cyc >= resp_at) begin
                check(resp_hit == eh, "R1", "hit flag", int'(resp_hit), int'(eh));
                check(resp_reject == er, "R7", "reject flag", int'(resp_reject), int'(er));
                check(int'(free_rows) == mfree, "R2/R5", "free rows", int'(free_rows), mfree);
                done = 1;
            end else begin
                cyc++;
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchecks++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
        $finish;
    end

    initial begin
        do_reset();
        run_req(1, 3);   // R2: slot 0
        run_req(2, 4);   // R2: slot 1
        run_req(3, 2);   // R2: slot 2
        run_req(1, 7);   // R1: hit, stored size 3 restores credit
        run_req(4, 5);   // R3: evicts id 3, R4 lowers credits
        run_req(9, 13);  // R7: oversize
        run_req(9, 0);   // R7: zero size
        run_req(5, 1);   // R4: id 1 now smallest
        run_req(6, 2);   // R2: last empty slot
        run_req(7, 1);   // R3: tie resolved to lowest slot
        run_req(8, 6);   // R6: several evictions
        run_req(10, 12); // R6: whole array
        run_req(10, 12); // R1: hit on full array
        do_reset();
        run_req(1, 1);
        run_req(2, 1);
        run_req(3, 1);
        run_req(4, 1);
        run_req(5, 1);   // R6: all slots used, rows free
        run_req(2, 1);   // R1: touch
        run_req(6, 2);   // R3: eviction order after touch
        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
        $finish;
    end

endmodule